// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five interrupt sources and a CPU sequencer. The sources are two external pins, two timer overflow events and a serial port flag pair (receive and transmit). The controller latches each event into a per-source flag and masks it with a per-source enable and a global enable. It then picks one winner, using a per-source priority bit and a fixed polling order inside each level. It presents a request together with the 16-bit vector address of the winner.

When the sequencer accepts the request by pulsing `ack`, the controller records the priority level of the winner in a two-entry in-service stack. For sources whose flag clears by hardware, it also emits a one-cycle flag-clear strobe. Low-level work can be pre-empted by a high-level request, but never by another low-level request. Nothing pre-empts high-level work. A `reti` pulse pops the most recent level, so returning from a nested high handler leaves the interrupted low handler in service.

Registers are written through a small select/data port. Select 0 holds the enables. Select 1 holds the priorities. Select 2 holds the trigger type of the external pins. Select 3 is the write-one-to-clear port for the serial flags.

Top module: `dual_prio_irq_ctrl`

## Requirements
- R1: After reset all enables, priorities and trigger types are 0, no flag is pending, nothing is in service, `irq_req` is 0 and `flag_clr` is 0.
- R2: Source index i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) can request only when bit i of the enable register (select 0) and the global bit 7 of that register are both 1.
- R3: The vector for source index i is 0x0003 + 8*i, giving 0003, 000B, 0013, 001B and 0023.
- R4: Among eligible sources of the same priority level, the lowest index wins.
- R5: A source whose bit in the priority register (select 1) is 1 is high level and beats every low-level source, whatever its index.
- R6: While a low-level handler is in service, low-level requests are withheld and high-level requests are still presented. While a high-level handler is in service, no request is presented.
- R7: `reti` leaves the high level if it is in service, and otherwise leaves the low level. After returning from a high handler nested in a low one, low-level requests stay withheld until a second `reti`.
- R8: Trigger register (select 2) bit 0 sets the mode of external 0 and bit 1 sets the mode of external 1. A value of 1 selects falling-edge mode, in which a 1-to-0 transition of the active-low pin latches a flag. A value of 0 selects level mode, in which the request follows the pin being low and disappears when the pin returns high.
- R9: When `ack` is high with `irq_req` high, `flag_clr` pulses the one-hot bit of the winner if the winner is a timer or an edge-mode external source, and that flag is cleared. A level-mode external source gets no strobe.
- R10: Serial receive and transmit events set two separate flags, and either one raises the serial request. `ack` neither clears them nor strobes `flag_clr`. Writing select 3 with bit 0 set clears the receive flag, and with bit 1 set clears the transmit flag.
- R11: `ack` while `irq_req` is 0 has no effect: no strobe, and no level becomes in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | Active-low external interrupt pins (bit 0 = external 0) |
| tmr_ovf | input | 2 | Timer overflow event pulses (bit 0 = timer 0) |
| ser_rx_evt | input | 1 | Serial receive-complete event pulse |
| ser_tx_evt | input | 1 | Serial transmit-complete event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 enable, 1 priority, 2 trigger, 3 serial clear) |
| reg_wdata | input | 8 | Register write data |
| ack | input | 1 | Sequencer has taken the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the sequencer |
| irq_vec | output | 16 | Vector address of the current winner |
| flag_clr | output | 5 | One-cycle flag-clear strobe, one bit per source index |

## Verification
The bench covers several corner cases, and each one has a characteristic failure:

- **Nesting.** A low handler is pre-empted by a high request, and then a further low request arrives during the high handler. A design that tracked only one level would show the low request after the first `reti` instead of after the second.
- **Simultaneous arrivals.** A design that ranked by index alone, ignoring priority, would return 000B where 001B is expected.
- **Flag clearing in both trigger modes.** A level-mode pin that is wrongly strobed, or a serial flag cleared by `ack`, shows up as a missing repeat request. A timer flag left set shows up as a request that should be gone.

Constrained-random rounds mix enables, priorities and event sets against a bench-side arbitration model.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int SRC_N = 5;
   localparam int IDX_W = 3;

   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      REG_ENABLE = 2'd0,
      REG_PRIO   = 2'd1,
      REG_TRIG   = 2'd2,
      REG_SERCLR = 2'd3
   } reg_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } isr_t;
endpackage

// File: rtl/irq_pin_cap.sv
module irq_pin_cap #(
   parameter int SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic pin_s;
   logic prev_q;
   logic eflag_q;
   logic fall;

   generate
      if (SYNC == 0) begin : g_direct
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= SYNC'({sh_q, pin_n});
         end
         assign pin_s = sh_q[SYNC-1];
      end
   endgenerate

   assign fall = prev_q & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         eflag_q <= 1'b0;
      end else begin
         prev_q  <= pin_s;
         eflag_q <= (fall & edge_mode) | (eflag_q & ~clr & edge_mode);
      end
   end

   assign req = edge_mode ? eflag_q : ~pin_s;
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int W  = 5,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  mask,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (mask[i]) begin
            valid = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_hi,
   input  logic pop,
   output logic lo_act,
   output logic hi_act
);
   isr_t st_q, st_n;

   always_comb begin
      st_n = st_q;
      if (pop) begin
         if (st_q.hi) st_n.hi = 1'b0;
         else         st_n.lo = 1'b0;
      end
      if (push) begin
         if (push_hi) st_n.hi = 1'b1;
         else         st_n.lo = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_n;
   end

   assign lo_act = st_q.lo;
   assign hi_act = st_q.hi;
endmodule

// File: rtl/dual_prio_irq_ctrl.sv
module dual_prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter int EXT_SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_n,
   input  logic [1:0]        tmr_ovf,
   input  logic              ser_rx_evt,
   input  logic              ser_tx_evt,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ack,
   input  logic              reti,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic [SRC_N-1:0]  flag_clr
);
   localparam int GLOBAL_BIT = DATA_W - 1;
   localparam int LAST_VEC   = VEC_BASE + (SRC_N - 1) * VEC_STRIDE;

   if (DATA_W < SRC_N + 1) begin : g_bad_data_w
      $error("DATA_W too small for enable bits plus global bit");
   end
   if (LAST_VEC >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("vector table does not fit in ADDR_W");
   end
   if (EXT_SYNC < 0 || EXT_SYNC > 3) begin : g_bad_sync
      $error("EXT_SYNC must be 0 to 3");
   end

   logic [SRC_N-1:0] en_r, prio_r;
   logic             all_r;
   logic [1:0]       trig_r;
   logic [1:0]       tmr_f;
   logic             ser_rx_f, ser_tx_f;
   logic [1:0]       ext_req;
   logic [SRC_N-1:0] src_flag, armed, hi_cand, lo_cand;
   logic             hi_v, lo_v;
   logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
   logic             win_hi;
   logic             take;
   logic [SRC_N-1:0] win_onehot, autoclr;
   logic             isr_lo, isr_hi;
   logic             wr_en, wr_prio, wr_trig, wr_serclr;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[GLOBAL_BIT-1:SRC_N];

   assign wr_en     = reg_we && (reg_sel == REG_ENABLE);
   assign wr_prio   = reg_we && (reg_sel == REG_PRIO);
   assign wr_trig   = reg_we && (reg_sel == REG_TRIG);
   assign wr_serclr = reg_we && (reg_sel == REG_SERCLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_r   <= '0;
         all_r  <= 1'b0;
         prio_r <= '0;
         trig_r <= '0;
      end else begin
         if (wr_en) begin
            en_r  <= reg_wdata[SRC_N-1:0];
            all_r <= reg_wdata[GLOBAL_BIT];
         end
         if (wr_prio) prio_r <= reg_wdata[SRC_N-1:0];
         if (wr_trig) trig_r <= reg_wdata[1:0];
      end
   end

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_ext
         irq_pin_cap #(.SYNC(EXT_SYNC)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[g]),
            .edge_mode (trig_r[g]),
            .clr       (flag_clr[2*g]),
            .req       (ext_req[g])
         );
      end
      for (g = 0; g < 2; g++) begin : g_tmr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tmr_f[g] <= 1'b0;
            else        tmr_f[g] <= tmr_ovf[g] | (tmr_f[g] & ~flag_clr[2*g+1]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_rx_f <= 1'b0;
         ser_tx_f <= 1'b0;
      end else begin
         ser_rx_f <= ser_rx_evt | (ser_rx_f & ~(wr_serclr & reg_wdata[0]));
         ser_tx_f <= ser_tx_evt | (ser_tx_f & ~(wr_serclr & reg_wdata[1]));
      end
   end

   assign src_flag = {ser_rx_f | ser_tx_f, tmr_f[1], ext_req[1], tmr_f[0], ext_req[0]};
   assign armed    = src_flag & en_r & {SRC_N{all_r}};
   assign hi_cand  = armed & prio_r & {SRC_N{~isr_hi}};
   assign lo_cand  = armed & ~prio_r & {SRC_N{~isr_hi & ~isr_lo}};

   irq_first_set #(.W(SRC_N), .IW(IDX_W)) u_pick_hi (
      .mask (hi_cand), .valid (hi_v), .idx (hi_idx)
   );
   irq_first_set #(.W(SRC_N), .IW(IDX_W)) u_pick_lo (
      .mask (lo_cand), .valid (lo_v), .idx (lo_idx)
   );

   assign win_hi  = hi_v;
   assign win_idx = hi_v ? hi_idx : lo_idx;
   assign irq_req = hi_v | lo_v;
   assign irq_vec = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);

   assign take       = ack & irq_req;
   assign win_onehot = SRC_N'(1) << win_idx;
   assign autoclr    = {1'b0, 1'b1, trig_r[1], 1'b1, trig_r[0]};
   assign flag_clr   = take ? (win_onehot & autoclr) : '0;

   irq_nest_track u_nest (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (take),
      .push_hi (win_hi),
      .pop     (reti),
      .lo_act  (isr_lo),
      .hi_act  (isr_hi)
   );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [ADDR_W-1:0] irq_vec,
   input logic [4:0]        flag_clr,
   input logic              ack,
   input logic              reti,
   input logic              all_en,
   input logic              isr_lo,
   input logic              isr_hi
);
   assert_req_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> all_en);

   assert_vec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B || irq_vec == 16'h0013 ||
                   irq_vec == 16'h001B || irq_vec == 16'h0023));

   assert_hi_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |-> !irq_req);

   assert_push_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req && !reti) |=> (isr_lo || isr_hi));

   assert_pop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && isr_hi && !ack) |=> !isr_hi);

   assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));

   assert_clr_needs_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr) |-> (ack && irq_req));
endmodule

bind dual_prio_irq_ctrl irq_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .irq_vec  (irq_vec),
   .flag_clr (flag_clr),
   .ack      (ack),
   .reti     (reti),
   .all_en   (all_r),
   .isr_lo   (isr_lo),
   .isr_hi   (isr_hi)
);

// File: tb/sim_dual_prio_irq_ctrl.sv
module sim_dual_prio_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_n = 2'b11;
   logic [1:0]  tmr_ovf = 2'b00;
   logic        ser_rx_evt = 1'b0, ser_tx_evt = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic        ack = 1'b0, reti = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [4:0]  flag_clr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
      .ser_rx_evt(ser_rx_evt), .ser_tx_evt(ser_tx_evt),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ack(ack), .reti(reti),
      .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr)
   );

   function automatic logic [15:0] exp_vec(input int idx);
      return 16'(3 + 8 * idx);
   endfunction

   function automatic logic [3:0] exp_pick(input logic [4:0] pend, input logic [4:0] pri,
                                           input logic lo, input logic hi);
      logic [4:0] hc, lc;
      hc = hi ? 5'b0 : (pend & pri);
      lc = (hi || lo) ? 5'b0 : (pend & ~pri);
      for (int i = 0; i < 5; i++) if (hc[i]) return {1'b1, 3'(i)};
      for (int i = 0; i < 5; i++) if (lc[i]) return {1'b1, 3'(i)};
      return 4'b0;
   endfunction

   task automatic chk_req(input string tag, input logic exp_r, input logic [15:0] exp_v);
      checks++;
      if (irq_req !== exp_r || (exp_r && irq_vec !== exp_v)) begin
         errors++;
         $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h",
                  tag, irq_req, irq_vec, exp_r, exp_v);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
      #1;
   endtask

   task automatic pulse_ev(input logic [4:0] ev, input logic tx);
      ext_n[0] = ~ev[0]; ext_n[1] = ~ev[2];
      tmr_ovf = {ev[3], ev[1]};
      ser_rx_evt = ev[4]; ser_tx_evt = tx;
      @(posedge clk); @(negedge clk);
      ext_n = 2'b11; tmr_ovf = 2'b00; ser_rx_evt = 1'b0; ser_tx_evt = 1'b0;
      #1;
   endtask

   task automatic do_ack(input string tag, input logic [4:0] exp_clr);
      ack = 1'b1;
      #1;
      checks++;
      if (flag_clr !== exp_clr) begin
         errors++;
         $display("FAIL %s: flag_clr=%b expected %b", tag, flag_clr, exp_clr);
      end
      @(posedge clk); @(negedge clk);
      ack = 1'b0;
      #1;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      @(posedge clk); @(negedge clk);
      reti = 1'b0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [4:0] mflag, men, mpri, ev;
      logic [3:0] p;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk_req("R1 reset request", 1'b0, 16'h0);
      checks++;
      if (flag_clr !== 5'b0) begin
         errors++; $display("FAIL R1 reset flag_clr=%b expected 00000", flag_clr);
      end
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk_req("R1 idle after reset", 1'b0, 16'h0);

      // R2: global enable gating
      wr(2'd0, 8'h02);
      pulse_ev(5'b00010, 1'b0);
      chk_req("R2 global off", 1'b0, 16'h0);
      wr(2'd0, 8'h82);
      chk_req("R2 global on", 1'b1, 16'h000B);
      do_ack("R9 timer0 strobe", 5'b00010);
      do_reti();
      chk_req("R9 timer0 cleared", 1'b0, 16'h0);

      // R4 / R3: same level, polling order
      wr(2'd0, 8'h9F);
      pulse_ev(5'b01010, 1'b0);
      chk_req("R4 lowest index wins", 1'b1, 16'h000B);
      do_ack("R9 timer0 strobe", 5'b00010);
      do_reti();
      chk_req("R3 timer1 vector", 1'b1, 16'h001B);
      do_ack("R9 timer1 strobe", 5'b01000);
      do_reti();
      chk_req("R9 both cleared", 1'b0, 16'h0);

      // R5: high priority beats lower index
      wr(2'd1, 8'h08);
      pulse_ev(5'b01010, 1'b0);
      chk_req("R5 high wins", 1'b1, 16'h001B);
      do_ack("R9 timer1 strobe", 5'b01000);
      do_reti();
      chk_req("R5 low next", 1'b1, 16'h000B);
      do_ack("R9 timer0 strobe", 5'b00010);
      do_reti();
      chk_req("R5 drained", 1'b0, 16'h0);

      // R6 / R7: nesting
      pulse_ev(5'b00010, 1'b0);
      do_ack("R9 timer0 strobe", 5'b00010);
      pulse_ev(5'b10000, 1'b0);
      chk_req("R6 low blocks low", 1'b0, 16'h0);
      pulse_ev(5'b01000, 1'b0);
      chk_req("R6 high preempts low", 1'b1, 16'h001B);
      do_ack("R9 timer1 strobe", 5'b01000);
      pulse_ev(5'b00010, 1'b0);
      chk_req("R6 high blocks all", 1'b0, 16'h0);
      do_reti();
      chk_req("R7 low still in service", 1'b0, 16'h0);
      do_reti();
      chk_req("R7 low released", 1'b1, 16'h000B);
      do_ack("R9 timer0 strobe", 5'b00010);
      do_reti();
      chk_req("R10 serial pending", 1'b1, 16'h0023);
      do_ack("R10 serial no strobe", 5'b00000);
      do_reti();
      chk_req("R10 serial survives ack", 1'b1, 16'h0023);
      pulse_ev(5'b00000, 1'b1);
      wr(2'd3, 8'h01);
      chk_req("R10 tx flag keeps request", 1'b1, 16'h0023);
      wr(2'd3, 8'h02);
      chk_req("R10 both serial cleared", 1'b0, 16'h0);

      // R8: level mode on external 0
      wr(2'd1, 8'h00);
      ext_n[0] = 1'b0;
      #1;
      chk_req("R8 level low requests", 1'b1, 16'h0003);
      do_ack("R9 level no strobe", 5'b00000);
      do_reti();
      chk_req("R8 level persists", 1'b1, 16'h0003);
      ext_n[0] = 1'b1;
      #1;
      chk_req("R8 level released", 1'b0, 16'h0);

      // R8: edge mode on external 1
      wr(2'd2, 8'h03);
      pulse_ev(5'b00100, 1'b0);
      chk_req("R8 edge latched", 1'b1, 16'h0013);
      do_ack("R9 edge strobe", 5'b00100);
      do_reti();
      chk_req("R9 edge cleared", 1'b0, 16'h0);

      // R11: ack without request
      do_ack("R11 idle ack no strobe", 5'b00000);
      pulse_ev(5'b00010, 1'b0);
      chk_req("R11 nothing pushed", 1'b1, 16'h000B);
      do_ack("R9 timer0 strobe", 5'b00010);
      do_reti();

      // Random rounds: R2 R3 R4 R5 R9 R10
      mflag = 5'b0;
      for (int it = 0; it < 40; it++) begin
         men  = 5'($urandom);
         mpri = 5'($urandom);
         ev   = 5'($urandom);
         wr(2'd0, {3'b100, men});
         wr(2'd1, {3'b000, mpri});
         pulse_ev(ev, 1'b0);
         mflag = mflag | ev;
         for (int k = 0; k < 6; k++) begin
            p = exp_pick(mflag & men, mpri, 1'b0, 1'b0);
            chk_req("R5 random arbitration", p[3], exp_vec(int'(p[2:0])));
            if (!p[3]) break;
            if (p[2:0] == 3'd4) begin
               do_ack("R10 random serial", 5'b00000);
               do_reti();
               wr(2'd3, 8'h03);
               mflag[4] = 1'b0;
            end else begin
               do_ack("R9 random strobe", 5'(1) << p[2:0]);
               do_reti();
               mflag[p[2:0]] = 1'b0;
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule